// File: doc/BRIEF.md
# Shared-Counter Single-Slope Conversion Back-End

This block is the digital half of a many-channel single-slope converter. A single counter advances in Gray code for the length of one analog ramp. Every channel watches its own comparator. The first time a comparator rises during the ramp, that channel records the Gray value of the counter at that moment. A channel whose comparator stays quiet until the ramp ends gets the full-scale code instead. When the ramp is over, a one-cycle completion strobe is raised. The recorded codes are then turned back into binary and delivered one channel at a time over a valid/ready stream.

Each ramp converts one stored analog cell of every channel at the same time. A sample index tells the analog side which cell to present. The index advances after the last channel of a ramp has been accepted, and wraps after the final cell. `ramp_active` is the enable for the external ramp generator. The comparator inputs are asynchronous, so each one passes through two flip-flops before it is used.

The stream follows these rules. `out_valid` is high for the whole readout phase. A word is transferred on any clock edge where `out_valid` and `out_ready` are both high. While `out_ready` stays low, the word and its channel number are held unchanged. No new ramp can start until the last word has been taken.

Top module: `wk_adc_backend`

## Requirements
- R1: After reset, `ramp_active`, `done` and `out_valid` are low and `sample_idx` is 0.
- R2: A `start` sampled high while idle starts a ramp. `ramp_active` is then high for exactly 2^CW cycles. `done` is high for the single cycle that follows and is low again on the next one.
- R3: Number the ramp cycles from 0, where cycle 0 is the first cycle in which `ramp_active` is high. If a comparator rises during cycle k, the result for that channel is k+2, as long as k+2 <= 2^CW-1. The extra two counts come from the synchronizer delay.
- R4: Within one ramp, only the first rising edge of a channel's comparator counts. Any later fall and rise of that comparator leaves its result unchanged.
- R5: A channel gets the full-scale result 2^CW-1 in three cases: its comparator never rises during the ramp, it rises too late for k+2 to fit, or it was already high before the ramp began.
- R6: After each ramp, the results are offered in ascending channel order, 0 to NCH-1, one word per channel. `out_chan` carries the channel number and `out_data` the plain binary result. `out_valid` falls after the last word is accepted.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold their values.
- R8: `sample_idx` is constant during a ramp. It increases by one once the last word of the readout is accepted, and goes from NSAMP-1 back to 0.
- R9: `start` has no effect during a ramp or during readout. `out_valid` is never high while `ramp_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a ramp (taken only when idle) |
| cmp_async | input | NCH | Comparator outputs, one per channel, asynchronous |
| ramp_active | output | 1 | High while the counter sweeps; enables the analog ramp |
| done | output | 1 | One-cycle strobe after the counter wraps |
| sample_idx | output | $clog2(NSAMP) | Analog cell to present for the next ramp |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | CW | Converted result, binary |
| out_chan | output | $clog2(NCH) | Channel number of `out_data` |

## Verification
A counter that is off by one, or a Gray code that is wrong, shows up at once as a bad value in the next readout. This is checked for trips at the very start and the very end of the ramp, where an error also changes whether the channel saturates. If a channel's capture flag is not cleared after the first edge, a second comparator pulse overwrites the result, and that word comes out wrong in the same readout. Errors in the phase control show up within one ramp: a ramp that runs too long or too short, a misplaced `done`, a stray start that is accepted, a sample index that does not advance, or words leaving in the wrong order or changing while stalled.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RAMP = 2'd1,
    PH_READ = 2'd2
  } phase_t;
endpackage

// File: rtl/wk_seq.sv
module wk_seq
  import wk_pkg::*;
#(
  parameter int CW    = 12,
  parameter int NSAMP = 64,
  localparam int SW   = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_finish,
  output phase_t        phase,
  output logic          ramp_on,
  output logic          ramp_last,
  output logic          arm,
  output logic [CW-1:0] gcode,
  output logic          done,
  output logic [SW-1:0] sample_idx
);
  localparam logic [CW-1:0] TOP_CNT  = {CW{1'b1}};
  localparam logic [SW-1:0] LAST_IDX = SW'(NSAMP - 1);

  phase_t        ph_q;
  logic [CW-1:0] bin_q, bin_nx, gray_q, gray_nx;
  logic          done_q;
  logic [SW-1:0] idx_q;

  assign bin_nx  = bin_q + 1'b1;
  assign gray_nx = bin_nx ^ (bin_nx >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bin_q  <= '0;
      gray_q <= '0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q   <= PH_RAMP;
            bin_q  <= '0;
            gray_q <= '0;
          end
        end
        PH_RAMP: begin
          bin_q  <= bin_nx;
          gray_q <= gray_nx;
          if (bin_q == TOP_CNT) begin
            ph_q   <= PH_READ;
            done_q <= 1'b1;
          end
        end
        PH_READ: begin
          if (rd_finish) begin
            ph_q  <= PH_IDLE;
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = ph_q;
  assign ramp_on    = (ph_q == PH_RAMP);
  assign ramp_last  = ramp_on && (bin_q == TOP_CNT);
  assign arm        = (ph_q == PH_IDLE) && start;
  assign gcode      = gray_q;
  assign done       = done_q;
  assign sample_idx = idx_q;
endmodule

// File: rtl/wk_chan.sv
module wk_chan #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp,
  input  logic          arm,
  input  logic          ramp_on,
  input  logic          ramp_last,
  input  logic [CW-1:0] gcode,
  output logic [CW-1:0] code
);
  // Gray code of the all-ones count
  localparam logic [CW-1:0] FULL_G = {1'b1, {(CW-1){1'b0}}};

  logic s1_q, s2_q, s3_q, armed_q;
  logic [CW-1:0] code_q;
  logic rise;

  assign rise = s2_q && !s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      armed_q <= 1'b0;
      code_q  <= '0;
    end else begin
      s1_q <= cmp;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (arm) begin
        armed_q <= 1'b1;
      end else if (ramp_on && armed_q) begin
        if (rise) begin
          code_q  <= gcode;
          armed_q <= 1'b0;
        end else if (ramp_last) begin
          code_q  <= FULL_G;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign code = code_q;
endmodule

// File: rtl/wk_rdout.sv
module wk_rdout #(
  parameter int NCH = 88,
  parameter int CW  = 12,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [CW-1:0]  codes [NCH],
  input  logic           out_ready,
  output logic           out_valid,
  output logic [CW-1:0]  out_data,
  output logic [CHW-1:0] out_chan,
  output logic           rd_finish
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  logic [CHW-1:0] ch_q;
  logic [CW-1:0]  g_sel, b_sel;
  logic           xfer;

  assign xfer = rd_en && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
    end else if (xfer) begin
      ch_q <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
    end
  end

  assign g_sel = codes[ch_q];

  always_comb begin
    b_sel[CW-1] = g_sel[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      b_sel[i] = b_sel[i+1] ^ g_sel[i];
    end
  end

  assign out_valid = rd_en;
  assign out_data  = b_sel;
  assign out_chan  = ch_q;
  assign rd_finish = xfer && (ch_q == LAST_CH);
endmodule

// File: rtl/wk_adc_backend.sv
module wk_adc_backend
  import wk_pkg::*;
#(
  parameter int NCH   = 88,
  parameter int CW    = 12,
  parameter int NSAMP = 64,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW   = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NCH-1:0] cmp_async,
  output logic           ramp_active,
  output logic           done,
  output logic [SW-1:0]  sample_idx,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CW-1:0]  out_data,
  output logic [CHW-1:0] out_chan
);
  phase_t        phase;
  logic          ramp_on, ramp_last, arm, rd_finish;
  logic [CW-1:0] gcode;
  logic [CW-1:0] codes [NCH];

  wk_seq #(.CW(CW), .NSAMP(NSAMP)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_finish  (rd_finish),
    .phase      (phase),
    .ramp_on    (ramp_on),
    .ramp_last  (ramp_last),
    .arm        (arm),
    .gcode      (gcode),
    .done       (done),
    .sample_idx (sample_idx)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wk_chan #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp       (cmp_async[g]),
      .arm       (arm),
      .ramp_on   (ramp_on),
      .ramp_last (ramp_last),
      .gcode     (gcode),
      .code      (codes[g])
    );
  end

  wk_rdout #(.NCH(NCH), .CW(CW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (phase == PH_READ),
    .codes     (codes),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .rd_finish (rd_finish)
  );

  assign ramp_active = ramp_on;
endmodule

// File: rtl/wk_adc_backend_chk.sv
module wk_adc_backend_chk #(
  parameter int NCH   = 88,
  parameter int CW    = 12,
  parameter int NSAMP = 64,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW   = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ramp_active,
  input logic           done,
  input logic [SW-1:0]  sample_idx,
  input logic           out_valid,
  input logic           out_ready,
  input logic [CW-1:0]  out_data,
  input logic [CHW-1:0] out_chan
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_after_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ramp_active) && !ramp_active);

  // R9
  no_read_in_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_active |-> !out_valid);

  // R8
  idx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_active |=> $stable(sample_idx));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sample_idx) < NSAMP);

  // R6
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_chan) < NCH);
endmodule

bind wk_adc_backend wk_adc_backend_chk #(.NCH(NCH), .CW(CW), .NSAMP(NSAMP)) u_chk (.*);

// File: tb/sim_wk_adc_backend.sv
module sim_wk_adc_backend;
  localparam int NCH   = 6;
  localparam int CW    = 6;
  localparam int NSAMP = 4;
  localparam int CHW   = $clog2(NCH);
  localparam int SW    = $clog2(NSAMP);
  localparam int FULL  = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [NCH-1:0] cmp_async = '0;
  logic           ramp_active, done, out_valid;
  logic           out_ready = 1'b0;
  logic [SW-1:0]  sample_idx;
  logic [CW-1:0]  out_data;
  logic [CHW-1:0] out_chan;

  int nvec = 0;
  int nfail = 0;
  int wd = 0;
  int exp_samp = 0;
  int kat [NCH];
  int mode [NCH];   // 0 single trip, 1 never, 2 high before ramp, 3 double pulse

  always #2 clk = ~clk;

  wk_adc_backend #(.NCH(NCH), .CW(CW), .NSAMP(NSAMP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_async(cmp_async),
    .ramp_active(ramp_active), .done(done), .sample_idx(sample_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(int m, int k);
    if (m == 1 || m == 2) return FULL;
    return (k + 2 <= FULL) ? k + 2 : FULL;
  endfunction

  function automatic string tag_of(int m, int k);
    if (m == 3) return "R4";
    if (m == 0 && k + 2 <= FULL) return "R3";
    return "R5";
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      nfail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  task automatic run_conv(int conv);
    int cyc;
    int ch;
    bit stalled;
    int held;
    for (int i = 0; i < NCH; i++) begin
      if (conv == 0) begin
        mode[i] = (i == 4) ? 1 : (i == 5) ? 2 : 0;
        kat[i]  = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? FULL - 2 : FULL - 1;
      end else if (conv == 1) begin
        mode[i] = (i < 3) ? 3 : 0;
        kat[i]  = 7 + i;
      end else begin
        int r = $urandom % 8;
        mode[i] = (r < 5) ? 0 : (r == 5) ? 1 : (r == 6) ? 2 : 3;
        kat[i]  = (mode[i] == 3) ? int'($urandom % (FULL - 10)) : int'($urandom % (FULL + 4));
      end
    end
    @(negedge clk);
    for (int i = 0; i < NCH; i++) cmp_async[i] = (mode[i] == 2);
    repeat (4) @(negedge clk);
    check(int'(sample_idx) == exp_samp, "R8", int'(sample_idx), exp_samp);
    check(!ramp_active, "R9", int'(ramp_active), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (ramp_active && cyc < 1000) begin
      for (int i = 0; i < NCH; i++) begin
        if ((mode[i] == 0 || mode[i] == 3) && kat[i] == cyc) cmp_async[i] = 1'b1;
        if (mode[i] == 3 && cyc == kat[i] + 4) cmp_async[i] = 1'b0;
        if (mode[i] == 3 && cyc == kat[i] + 6) cmp_async[i] = 1'b1;
      end
      start = (cyc == 5);  // stray request inside the ramp (R9)
      if (cyc == 9) check(!out_valid, "R9", int'(out_valid), 0);
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == (1 << CW), "R2", cyc, 1 << CW);
    check(done, "R2", int'(done), 1);
    ch = 0;
    stalled = 1'b0;
    held = 0;
    while (ch < NCH && cyc < 5000) begin
      int e = expect_code(mode[ch], kat[ch]);
      if (cyc == (1 << CW) + 1) check(!done, "R2", int'(done), 0);
      start = (ch == 0);  // request during readout is ignored (R9)
      out_ready = ($urandom % 3) != 0;
      check(out_valid, "R6", int'(out_valid), 1);
      check(int'(out_chan) == ch, "R6", int'(out_chan), ch);
      check(int'(out_data) == e, tag_of(mode[ch], kat[ch]), int'(out_data), e);
      if (stalled) check(int'(out_data) == held, "R7", int'(out_data), held);
      stalled = !out_ready;
      held = int'(out_data);
      if (out_ready) ch++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    exp_samp = (exp_samp + 1) % NSAMP;
    check(!out_valid, "R6", int'(out_valid), 0);
    check(!ramp_active, "R9", int'(ramp_active), 0);
    check(int'(sample_idx) == exp_samp, "R8", int'(sample_idx), exp_samp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!ramp_active, "R1", int'(ramp_active), 0);
    check(!done, "R1", int'(done), 0);
    check(!out_valid, "R1", int'(out_valid), 0);
    check(sample_idx == '0, "R1", int'(sample_idx), 0);
    for (int c = 0; c < 10; c++) run_conv(c);
    report();
    $finish;
  end
endmodule